// File: doc/BRIEF.md
# Brown-out Step Dimming Controller

This block keeps track of which of four output-current reference levels a lighting power stage should use. Every brown-out event (a rising edge of the brown-out-not-OK indication) moves the selection one step lower: full current, then 70 %, then 25 %, then 5 %, and from 5 % back to full current. The chosen step survives ordinary brown-outs, so a power-cycled fixture comes back one dimming level lower. This lets a user dim a lamp with nothing but its wall switch.

Two things return the controller to full current. The first is a supply reset, which acts at once and without a clock. The second is a brown-out that lasts without a break for a programmable number of slow timebase ticks; the default count matches about three seconds at a 100 Hz tick. The one-hot level select drives the analog reference multiplexer. The startup-dimming flag tells the switching logic that it should start from a time-out pulse, because a dimmed step is in use.

Top module: `stepdim_top`

## Requirements
- R1: While `supplyRst` is high, and immediately upon its assertion with no clock edge, `stepIdx` is 0, `refSel` is 4'b0001 and `startupDim` is 0.
- R2: A rising edge of `boNotOk` passes through a two-flop synchronizer and advances `stepIdx` by one on the third rising clock edge after the input changes. Holding `boNotOk` high gives exactly one increment.
- R3: An advance from step 3 (5 % current) wraps `stepIdx` to 0 (full current).
- R4: `refSel` is one-hot, with bit `stepIdx` set: bit 0 is full current, bit 1 is 70 %, bit 2 is 25 % and bit 3 is 5 %.
- R5: `startupDim` is 1 exactly when `stepIdx` is nonzero.
- R6: `boLevel` is synchronized by two flops. Once it is seen high, the HOLD_TICKS-th `tick` pulse with `boLevel` still continuously high clears `stepIdx` to 0 on that same clock edge. After HOLD_TICKS-1 such pulses the step is unchanged.
- R7: The hold clear fires only once per continuous brown-out. Further ticks, and a step advanced after the clear, are left alone until `boLevel` drops.
- R8: If `boLevel` falls before the count completes, the hold count restarts from zero and the stored step is kept. A later brown-out needs the full HOLD_TICKS pulses to clear.
- R9: When an advance and a hold clear fall on the same clock edge, the clear wins and `stepIdx` becomes 0.
- R10: `tick` pulses while `boLevel` is low have no effect on `stepIdx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| supplyRst | input | 1 | Asynchronous supply reset, active high |
| boNotOk | input | 1 | Brown-out-not-OK event indication, asynchronous |
| boLevel | input | 1 | High while the sense voltage is below the brown-out-off threshold, asynchronous |
| tick | input | 1 | One-clock pulse from the slow timebase |
| stepIdx | output | 2 | Current dimming step, 0 = full current |
| refSel | output | 4 | One-hot reference level select |
| startupDim | output | 1 | High when a dimmed step is in use |

## Verification
The step advance and the hold clear can land on the same clock edge, because they come from independent inputs. The bench provokes this collision deliberately. It first brings the hold count to one tick short of its terminal value, with the step nonzero. It then raises `boNotOk` and times a single `tick` pulse to the cycle in which the synchronized edge is detected. The expected result is step 0, not the previous step plus one, and the clear-priority assertion checks the same case at the strobe level.

// File: rtl/stepdim_pkg.sv
package stepdim_pkg;

  // number of reference levels and width of the step index
  localparam int unsigned LEVELS = 4;
  localparam int unsigned STEP_W = $clog2(LEVELS);

  // strobes from the control half to the step datapath
  typedef struct packed {
    logic advance;   // one brown-out event seen
    logic clear;     // continuous brown-out reached hold time
  } stepStrobe_t;

endpackage

// File: rtl/stepdim_ctrl.sv
module stepdim_ctrl
  import stepdim_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_TICKS  = 300
) (
  input  logic        clk,
  input  logic        supplyRst,
  input  logic        boNotOk,
  input  logic        boLevel,
  input  logic        tick,
  output stepStrobe_t strobes
);

  localparam int unsigned CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_TICKS - 1);

  logic [SYNC_STAGES-1:0] evtSync;
  logic [SYNC_STAGES-1:0] lvlSync;
  logic                   evtPrev;
  logic                   evtSeen;
  logic                   lvlSeen;
  logic [CNT_W-1:0]       holdCnt;
  logic                   holdFired;
  logic                   holdDone;

  // two-or-more flop synchronizers for the asynchronous inputs
  always_ff @(posedge clk or posedge supplyRst) begin
    if (supplyRst) begin
      evtSync <= '0;
      lvlSync <= '0;
      evtPrev <= 1'b0;
    end else begin
      evtSync <= {evtSync[SYNC_STAGES-2:0], boNotOk};
      lvlSync <= {lvlSync[SYNC_STAGES-2:0], boLevel};
      evtPrev <= evtSeen;
    end
  end

  assign evtSeen = evtSync[SYNC_STAGES-1];
  assign lvlSeen = lvlSync[SYNC_STAGES-1];

  // hold timer: counts ticks of a continuous brown-out, fires once
  always_ff @(posedge clk or posedge supplyRst) begin
    if (supplyRst) begin
      holdCnt   <= '0;
      holdFired <= 1'b0;
    end else if (!lvlSeen) begin
      holdCnt   <= '0;
      holdFired <= 1'b0;
    end else if (tick && !holdFired) begin
      if (holdCnt == LAST_CNT) begin
        holdCnt   <= '0;
        holdFired <= 1'b1;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  assign holdDone = lvlSeen & tick & ~holdFired & (holdCnt == LAST_CNT);

  always_comb begin
    strobes.advance = evtSeen & ~evtPrev;
    strobes.clear   = holdDone;
  end

endmodule

// File: rtl/stepdim_datapath.sv
module stepdim_datapath
  import stepdim_pkg::*;
(
  input  logic              clk,
  input  logic              supplyRst,
  input  stepStrobe_t       strobes,
  output logic [STEP_W-1:0] stepIdx,
  output logic [LEVELS-1:0] refSel,
  output logic              startupDim
);

  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] stepNext;

  // clear has priority over advance; advance wraps naturally
  always_comb begin
    stepNext = stepQ;
    if (strobes.clear) begin
      stepNext = '0;
    end else if (strobes.advance) begin
      stepNext = stepQ + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge supplyRst) begin
    if (supplyRst) begin
      stepQ <= '0;
    end else begin
      stepQ <= stepNext;
    end
  end

  // one select line per reference level
  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_sel
    assign refSel[lvl] = (stepQ == STEP_W'(lvl));
  end

  assign stepIdx    = stepQ;
  assign startupDim = |stepQ;

endmodule

// File: rtl/stepdim_top.sv
module stepdim_top
  import stepdim_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_TICKS  = 300
) (
  input  logic              clk,
  input  logic              supplyRst,
  input  logic              boNotOk,
  input  logic              boLevel,
  input  logic              tick,
  output logic [STEP_W-1:0] stepIdx,
  output logic [LEVELS-1:0] refSel,
  output logic              startupDim
);

  stepStrobe_t strobes;

  stepdim_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .supplyRst(supplyRst),
    .boNotOk  (boNotOk),
    .boLevel  (boLevel),
    .tick     (tick),
    .strobes  (strobes)
  );

  stepdim_datapath u_dp (
    .clk       (clk),
    .supplyRst (supplyRst),
    .strobes   (strobes),
    .stepIdx   (stepIdx),
    .refSel    (refSel),
    .startupDim(startupDim)
  );

endmodule

// File: rtl/stepdim_chk.sv
module stepdim_chk
  import stepdim_pkg::*;
(
  input logic              clk,
  input logic              supplyRst,
  input stepStrobe_t       strobes,
  input logic [STEP_W-1:0] stepIdx,
  input logic [LEVELS-1:0] refSel,
  input logic              startupDim
);

  // R4: select is one-hot and points at the current step
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (supplyRst)
    ($countones(refSel) == 1) && refSel[stepIdx]);

  // R5: startup-dimming flag tracks a nonzero step
  a_r5_dim_flag: assert property (@(posedge clk) disable iff (supplyRst)
    startupDim == (stepIdx != '0));

  // R2 / R3: a lone advance moves one step, wrapping at the top
  a_r2_advance_one: assert property (@(posedge clk) disable iff (supplyRst)
    (strobes.advance && !strobes.clear) |=> (stepIdx == STEP_W'($past(stepIdx) + 1'b1)));

  // R9 / R6: any clear, even alongside an advance, lands on full current
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (supplyRst)
    strobes.clear |=> (stepIdx == '0));

  // R7: clear never repeats on consecutive cycles
  a_r7_clear_once: assert property (@(posedge clk) disable iff (supplyRst)
    strobes.clear |=> !strobes.clear);

  // R8 / R10: without a strobe the step holds
  a_r8_step_stable: assert property (@(posedge clk) disable iff (supplyRst)
    (!strobes.advance && !strobes.clear) |=> $stable(stepIdx));

endmodule

bind stepdim_top stepdim_chk u_chk (
  .clk       (clk),
  .supplyRst (supplyRst),
  .strobes   (strobes),
  .stepIdx   (stepIdx),
  .refSel    (refSel),
  .startupDim(startupDim)
);

// File: tb/stepdim_top_tb.sv
`timescale 1ns/1ps
module stepdim_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 6;

  logic       clk = 1'b0;
  logic       supplyRst = 1'b1;
  logic       boNotOk = 1'b0;
  logic       boLevel = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] stepIdx;
  logic [3:0] refSel;
  logic       startupDim;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepdim_top #(.SYNC_STAGES(2), .HOLD_TICKS(HOLD)) u_dut (
    .clk(clk), .supplyRst(supplyRst), .boNotOk(boNotOk), .boLevel(boLevel),
    .tick(tick), .stepIdx(stepIdx), .refSel(refSel), .startupDim(startupDim)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // checks step, select and flag together
  task automatic checkStep(input string req, input int exp);
    check(req, stepIdx, exp);
    check({req, " refSel"}, refSel, 1 << exp);
    check({req, " startupDim"}, startupDim, (exp != 0) ? 1 : 0);
  endtask

  task automatic doReset();
    @(negedge clk); supplyRst = 1'b1; boNotOk = 0; boLevel = 0; tick = 0;
    repeat (2) @(negedge clk);
    supplyRst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseEvent();
    @(negedge clk); boNotOk = 1'b1;
    repeat (4) @(negedge clk);
    boNotOk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic giveTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic levelOn();
    @(negedge clk); boLevel = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic levelOff();
    @(negedge clk); boLevel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    checkStep("R1 reset", 0);
  endtask

  task automatic t_timing();
    // R2: exact edge of the increment
    @(negedge clk); boNotOk = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not before third edge", stepIdx, 0);
    @(negedge clk);
    check("R2 after third edge", stepIdx, 1);
    repeat (6) @(negedge clk);
    check("R2 held high gives one step", stepIdx, 1);
    boNotOk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_walk_wrap();
    pulseEvent(); checkStep("R4 step 2", 2);
    pulseEvent(); checkStep("R4 step 3", 3);
    pulseEvent(); checkStep("R3 wrap to 0", 0);
    pulseEvent(); checkStep("R5 step 1", 1);
  endtask

  task automatic t_idle_ticks();
    giveTicks(HOLD + 2);
    check("R10 ticks with level low", stepIdx, 1);
  endtask

  task automatic t_short();
    pulseEvent();                 // step 2
    levelOn(); giveTicks(HOLD - 1);
    check("R6 one tick short keeps step", stepIdx, 2);
    levelOff();
    check("R8 short brown-out keeps step", stepIdx, 2);
    levelOn(); giveTicks(HOLD - 1);
    check("R8 count restarted", stepIdx, 2);
    giveTicks(1);
    checkStep("R6 hold clear", 0);
  endtask

  task automatic t_once();
    pulseEvent();                 // level still high, fired
    check("R7 advance after clear", stepIdx, 1);
    giveTicks(2 * HOLD);
    check("R7 no second clear", stepIdx, 1);
    levelOff();
  endtask

  task automatic t_collide();
    pulseEvent();                 // step 2
    levelOn(); giveTicks(HOLD - 1);
    @(negedge clk); boNotOk = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R9 clear beats advance", stepIdx, 0);
    repeat (3) @(negedge clk);
    check("R9 no late advance", stepIdx, 0);
    boNotOk = 1'b0;
    levelOff();
  endtask

  task automatic t_async();
    pulseEvent(); pulseEvent();
    check("R1 setup step", stepIdx, 2);
    @(negedge clk); #2 supplyRst = 1'b1; #1;
    checkStep("R1 async clear", 0);
    @(negedge clk); supplyRst = 1'b0;
    @(negedge clk);
    checkStep("R1 after release", 0);
  endtask

  initial begin
    doReset();
    t_reset();
    t_timing();
    t_walk_wrap();
    t_idle_ticks();
    t_short();
    t_once();
    t_collide();
    t_async();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule